// File: doc/BRIEF.md
# Page Write Buffer and Programming Timer

This block sits between a byte-wide write interface and a non-volatile byte array, which is modelled here as ordinary storage. Once an upstream unlock detector says that writes are allowed, the first write strobe opens a page load. That strobe and the ones after it drop bytes into a 64-entry page register, and a per-byte flag records which entries were loaded. The load has no byte count. It ends when no accepted strobe has arrived for a set number of clock cycles. The block then becomes busy for a fixed number of cycles. During the first 64 of those cycles it walks the page register and commits only the flagged bytes to the array. When the busy period ends, the flags clear.

Address bits [ADDR_W-1:6] name the page and bits [5:0] name the byte within it. The page of the first strobe is held for the whole load, and strobes that name another page are dropped. A separate guard input reports a write attempt that the unlock logic rejected. That attempt runs the full busy period and changes nothing. The last accepted address and data are kept on outputs for status reporting, and a synchronous read port gives access to the array.

Both the inactivity window (`LOAD_TO_CYC`) and the busy time (`PROG_CYC`, at least 64) are given in clock cycles. An address width of 13 gives an 8K x 8 array. The default is 12 bits, which keeps the elaborated storage small.

Top module: `page_write_engine`

## Requirements
- R1: After reset, `busy` is 0 and `last_addr` and `last_data` are 0.
- R2: When `unlock_ok` is 1, a strobe seen in the idle state opens a load. If no further strobe is accepted, `busy` goes to 1 exactly `LOAD_TO_CYC` cycles after the clock edge that sampled the last accepted strobe.
- R3: A strobe for the held page that is sampled at or before the edge where the window would expire is accepted and restarts the window.
- R4: Bytes may be loaded in any order. If a byte is loaded more than once in one load, the array receives the value from its last strobe.
- R5: Only bytes that were loaded are written to the array. Every other byte of the page keeps its earlier content.
- R6: During a load, a strobe whose address bits [ADDR_W-1:6] differ from the held page is ignored. It changes no buffer entry and no status output, and it does not restart the window.
- R7: `busy` stays high for exactly `PROG_CYC` cycles. Strobes and guard pulses that arrive while it is high have no effect.
- R8: A `guard_hit` pulse sampled in the idle state, with no accepted strobe on the same edge, holds `busy` high for `PROG_CYC` cycles starting at the next edge and leaves the array unchanged.
- R9: A strobe sampled in the idle state while `unlock_ok` is 0 is ignored.
- R10: `last_addr` and `last_data` show the address and data of the most recent accepted strobe, from the edge after it is sampled.
- R11: `rd_data` shows the array content at `rd_addr` one clock edge after `rd_addr` is sampled.
- R12: The loaded flags are clear when `busy` falls, so bytes flagged in one load are never committed by a later load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | Single-cycle write strobe |
| wr_addr | input | ADDR_W | Write address: page in [ADDR_W-1:6], byte in [5:0] |
| wr_data | input | DATA_W | Write data |
| unlock_ok | input | 1 | Writes allowed; sampled only by the strobe that opens a load |
| guard_hit | input | 1 | Pulse: a protected write attempt was rejected upstream |
| busy | output | 1 | Programming period running |
| last_addr | output | ADDR_W | Address of the last accepted strobe |
| last_data | output | DATA_W | Data of the last accepted strobe |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array read data, one cycle latency |

## Verification
Every timed result is counted from the clock edge that sampled the causing input. Status outputs are due one edge later. `busy` rises exactly `LOAD_TO_CYC` edges after the last accepted strobe, or one edge after a guard pulse, and falls `PROG_CYC` edges after it rises. Read data is due one edge after the address. The bench drives and samples on falling edges and counts whole cycles from the strobe. It checks that `busy` is still low one cycle before the rise and still high one cycle before the fall, so an off-by-one in either timer is reported. It checks array contents only after `busy` has fallen.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
  localparam int PAGE_BITS  = 6;
  localparam int PAGE_BYTES = 1 << PAGE_BITS;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pwe_state_e;
endpackage

// File: rtl/pwe_timer.sv
module pwe_timer #(
  parameter int MAX_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic zero
);
  localparam int W = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);
  localparam logic [W-1:0] RELOAD = W'(MAX_CYC - 1);

  logic [W-1:0] cnt_q;

  function automatic logic [W-1:0] step_down(input logic [W-1:0] c);
    return (c == '0) ? c : c - W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= RELOAD;
    else if (run)    cnt_q <= step_down(cnt_q);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pwe_page_buf.sv
module pwe_page_buf import pwe_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [PAGE_BITS-1:0] wr_slot,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 clr,
  input  logic [PAGE_BITS-1:0] rd_slot,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_loaded,
  output logic [PAGE_BYTES-1:0] loaded_mask
);
  logic [DATA_W-1:0]     data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    localparam logic [PAGE_BITS-1:0] IDX = PAGE_BITS'(s);
    logic hit;
    assign hit = wr_en && (wr_slot == IDX);

    always_ff @(posedge clk) begin
      if (hit) data_q[s] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mask_q[s] <= 1'b0;
      else if (clr) mask_q[s] <= 1'b0;
      else if (hit) mask_q[s] <= 1'b1;
    end
  end

  assign rd_data     = data_q[rd_slot];
  assign rd_loaded   = mask_q[rd_slot];
  assign loaded_mask = mask_q;
endmodule

// File: rtl/pwe_array.sv
module pwe_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
    rdata <= mem_q[raddr];
  end
endmodule

// File: rtl/pwe_ctrl.sv
module pwe_ctrl import pwe_pkg::*; #(
  parameter int PG_W        = 6,
  parameter int LOAD_TO_CYC = 20000,
  parameter int PROG_CYC    = 2000000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [PG_W-1:0]      wr_page,
  input  logic                 unlock_ok,
  input  logic                 guard_hit,
  output logic                 accept,
  output logic                 busy,
  output logic                 commit_phase,
  output logic                 prog_done,
  output logic                 dummy_run,
  output logic [PG_W-1:0]      page_q,
  output logic [PAGE_BITS-1:0] walk_slot
);
  localparam int WALK_W = PAGE_BITS + 1;

  pwe_state_e        state_q, state_d;
  logic [WALK_W-1:0] walk_q;
  logic              lt_zero, pt_zero;
  logic              guard_start, enter_prog;
  logic              in_idle, in_load, in_prog;

  function automatic logic same_page(input logic [PG_W-1:0] a, input logic [PG_W-1:0] b);
    return a == b;
  endfunction

  function automatic logic walk_live(input logic [WALK_W-1:0] w);
    return w < WALK_W'(PAGE_BYTES);
  endfunction

  assign in_idle = (state_q == ST_IDLE);
  assign in_load = (state_q == ST_LOAD);
  assign in_prog = (state_q == ST_PROG);

  assign accept = wr_stb && ((in_idle && unlock_ok) ||
                             (in_load && same_page(wr_page, page_q)));
  assign guard_start = in_idle && guard_hit && !accept;
  assign enter_prog  = guard_start || (in_load && !accept && lt_zero);
  assign prog_done   = in_prog && pt_zero;

  pwe_timer #(.MAX_CYC(LOAD_TO_CYC)) u_load_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept),
    .run  (in_load),
    .zero (lt_zero)
  );

  pwe_timer #(.MAX_CYC(PROG_CYC)) u_prog_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (enter_prog),
    .run  (in_prog),
    .zero (pt_zero)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept)           state_d = ST_LOAD;
        else if (guard_start) state_d = ST_PROG;
      end
      ST_LOAD: if (enter_prog) state_d = ST_PROG;
      ST_PROG: if (prog_done)  state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      page_q    <= '0;
      walk_q    <= '0;
      dummy_run <= 1'b0;
    end else begin
      state_q <= state_d;
      if (in_idle && accept) page_q <= wr_page;
      if (enter_prog)                      walk_q <= '0;
      else if (in_prog && walk_live(walk_q)) walk_q <= walk_q + WALK_W'(1);
      if (guard_start)    dummy_run <= 1'b1;
      else if (prog_done) dummy_run <= 1'b0;
    end
  end

  assign busy         = in_prog;
  assign commit_phase = in_prog && walk_live(walk_q);
  assign walk_slot    = walk_q[PAGE_BITS-1:0];

  AST_PROG_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!accept)); // R2
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_load && $past(in_load)) |-> $stable(page_q)); // R6
  AST_BUSY_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy); // R7
endmodule

// File: rtl/page_write_engine.sv
module page_write_engine import pwe_pkg::*; #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 8,
  parameter int LOAD_TO_CYC = 20000,
  parameter int PROG_CYC    = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              unlock_ok,
  input  logic              guard_hit,
  output logic              busy,
  output logic [ADDR_W-1:0] last_addr,
  output logic [DATA_W-1:0] last_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PG_W = ADDR_W - PAGE_BITS;

  logic                  accept, commit_phase, prog_done, dummy_run;
  logic [PG_W-1:0]       page_q;
  logic [PAGE_BITS-1:0]  walk_slot;
  logic [DATA_W-1:0]     buf_data;
  logic                  slot_loaded;
  logic [PAGE_BYTES-1:0] loaded_mask;
  logic                  mem_we;

  pwe_ctrl #(
    .PG_W       (PG_W),
    .LOAD_TO_CYC(LOAD_TO_CYC),
    .PROG_CYC   (PROG_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb      (wr_stb),
    .wr_page     (wr_addr[ADDR_W-1:PAGE_BITS]),
    .unlock_ok   (unlock_ok),
    .guard_hit   (guard_hit),
    .accept      (accept),
    .busy        (busy),
    .commit_phase(commit_phase),
    .prog_done   (prog_done),
    .dummy_run   (dummy_run),
    .page_q      (page_q),
    .walk_slot   (walk_slot)
  );

  pwe_page_buf #(.DATA_W(DATA_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (accept),
    .wr_slot    (wr_addr[PAGE_BITS-1:0]),
    .wr_data    (wr_data),
    .clr        (prog_done),
    .rd_slot    (walk_slot),
    .rd_data    (buf_data),
    .rd_loaded  (slot_loaded),
    .loaded_mask(loaded_mask)
  );

  assign mem_we = commit_phase && slot_loaded;

  pwe_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk  (clk),
    .we   (mem_we),
    .waddr({page_q, walk_slot}),
    .wdata(buf_data),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= '0;
      last_data <= '0;
    end else if (accept) begin
      last_addr <= wr_addr;
      last_data <= wr_data;
    end
  end

  AST_COMMIT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R5
  AST_MASK_EMPTY_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (loaded_mask == '0)); // R12
  AST_GUARD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_run |-> !mem_we); // R8
  AST_LAST_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (last_addr == $past(wr_addr)) && (last_data == $past(wr_data))); // R10
endmodule

// File: tb/test_page_write_engine.sv
`timescale 1ns/100ps
module test_page_write_engine;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int LT = 12;
  localparam int PC = 80;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          unlock_ok = 1'b0;
  logic          guard_hit = 1'b0;
  logic          busy;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_data;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp2 [64];

  always #2.5 clk = ~clk;

  page_write_engine #(.ADDR_W(AW), .DATA_W(DW), .LOAD_TO_CYC(LT), .PROG_CYC(PC)) i_page_write_engine (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .unlock_ok(unlock_ok), .guard_hit(guard_hit), .busy(busy), .last_addr(last_addr),
    .last_data(last_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [AW-1:0] mk(input int pg, input int sl);
    return AW'((pg << 6) | (sl & 63));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic stb(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  // Called at the falling edge right after the last accepted strobe.
  task automatic prog_window(input string req);
    idle(LT - 1);
    chk({req, " busy before window end"}, 32'(busy), 32'd0);
    idle(1);
    chk({req, " busy at window end"}, 32'(busy), 32'd1);
    idle(PC - 1);
    chk("R7 busy held", 32'(busy), 32'd1);
    idle(1);
    chk("R7 busy released", 32'(busy), 32'd0);
  endtask

  task automatic check_page2(input string req);
    logic [DW-1:0] v;
    int bad = 0;
    for (int i = 0; i < 64; i++) begin
      rd(mk(2, i), v);
      if (v !== exp2[i]) begin
        bad++;
        $display("FAIL %s byte %0d act=%0h exp=%0h", req, i, v, exp2[i]);
      end
    end
    checks = checks + 1;
    if (bad != 0) errors = errors + 1;
  endtask

  task automatic t_reset;
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 last_addr", 32'(last_addr), 32'd0);
    chk("R1 last_data", 32'(last_data), 32'd0);
  endtask

  task automatic t_fill;
    unlock_ok = 1'b1;
    for (int i = 63; i >= 0; i--) begin
      exp2[i] = DW'(i) ^ 8'h5A;
      stb(mk(2, i), exp2[i]);
    end
    exp2[3] = 8'hC3;
    stb(mk(2, 3), 8'hC3);
    chk("R10 last_addr", 32'(last_addr), 32'(mk(2, 3)));
    chk("R10 last_data", 32'(last_data), 32'hC3);
    prog_window("R2");
    check_page2("R4 R11 full page");
  endtask

  task automatic t_partial;
    exp2[1] = 8'hE1;
    stb(mk(2, 1), 8'hE1);
    idle(3);
    exp2[7] = 8'hE7;
    stb(mk(2, 7), 8'hE7);
    prog_window("R2 partial");
    check_page2("R5 untouched bytes");
  endtask

  task automatic t_window;
    logic [DW-1:0] v;
    stb(mk(3, 0), 8'h30);
    idle(LT - 1);
    chk("R3 busy before late strobe", 32'(busy), 32'd0);
    stb(mk(3, 1), 8'h31);
    prog_window("R3");
    rd(mk(3, 0), v);
    chk("R3 first byte", 32'(v), 32'h30);
    rd(mk(3, 1), v);
    chk("R3 late byte", 32'(v), 32'h31);
  endtask

  task automatic t_foreign;
    logic [DW-1:0] v;
    stb(mk(4, 0), 8'h40);
    idle(2);
    stb(mk(5, 0), 8'h50);
    chk("R6 last_addr", 32'(last_addr), 32'(mk(4, 0)));
    chk("R6 last_data", 32'(last_data), 32'h40);
    idle(LT - 4);
    chk("R6 busy before original window end", 32'(busy), 32'd0);
    idle(1);
    chk("R6 window not restarted", 32'(busy), 32'd1);
    idle(PC);
    chk("R6 busy released", 32'(busy), 32'd0);
    rd(mk(4, 0), v);
    chk("R6 buffer byte kept", 32'(v), 32'h40);
  endtask

  task automatic t_busy_ignore;
    logic [DW-1:0] v;
    stb(mk(6, 20), 8'h66);
    idle(LT);
    chk("R7 busy up", 32'(busy), 32'd1);
    stb(mk(2, 9), 8'hAB);
    guard_hit = 1'b1;
    idle(1);
    guard_hit = 1'b0;
    idle(PC - 3);
    chk("R7 busy not extended early", 32'(busy), 32'd1);
    idle(1);
    chk("R7 busy not extended", 32'(busy), 32'd0);
    idle(LT + 3);
    chk("R7 no load after busy", 32'(busy), 32'd0);
    chk("R7 last_addr", 32'(last_addr), 32'(mk(6, 20)));
    rd(mk(2, 9), v);
    chk("R7 array unchanged", 32'(v), 32'(exp2[9]));
  endtask

  task automatic t_mask;
    logic [DW-1:0] v;
    exp2[21] = 8'h21;
    stb(mk(2, 21), 8'h21);
    prog_window("R2 mask");
    rd(mk(2, 20), v);
    chk("R12 stale byte not committed", 32'(v), 32'(exp2[20]));
    rd(mk(2, 21), v);
    chk("R12 new byte", 32'(v), 32'h21);
  endtask

  task automatic t_guard;
    guard_hit = 1'b1;
    idle(1);
    guard_hit = 1'b0;
    chk("R8 busy after guard", 32'(busy), 32'd1);
    idle(PC - 1);
    chk("R8 busy held", 32'(busy), 32'd1);
    idle(1);
    chk("R8 busy released", 32'(busy), 32'd0);
    check_page2("R8 array unchanged");
  endtask

  task automatic t_locked;
    logic [DW-1:0] v;
    unlock_ok = 1'b0;
    stb(mk(2, 30), 8'h77);
    idle(LT + 2);
    chk("R9 no busy", 32'(busy), 32'd0);
    chk("R9 last_addr", 32'(last_addr), 32'(mk(2, 21)));
    rd(mk(2, 30), v);
    chk("R9 array unchanged", 32'(v), 32'(exp2[30]));
    unlock_ok = 1'b1;
  endtask

  initial begin
    idle(3);
    t_reset;
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_fill;
    t_partial;
    t_window;
    t_foreign;
    t_busy_ignore;
    t_mask;
    t_guard;
    t_locked;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule